// File: doc/BRIEF.md
# Subscriber line mode controller

This block is the digital control core of an analog telephone line interface. A line card controller selects one of four operating conditions with two level inputs: a standby request and a ring request. Two raw comparator outputs from the analog front end report loop current (the phone is off-hook) and ground key (current flowing from a wire to ground). The block turns these into four outputs. Three are active-low status signals: hook, ground key and codec power-up. The fourth is an active-high enable for a ringing injector.

Both detector inputs pass through a two-flop synchronizer and then a saturating up/down counter. A detection is qualified only when the counter reaches its programmable limit, and it is released only when the counter returns to zero. The hook and ground-key counters each have their own limit, so each detector has its own time constant.

While the line is ringing, a qualified off-hook (ring trip) or a qualified ground key drops the injector enable in the same cycle that the status output changes. A latch then holds the enable low until the ring request is withdrawn.

Top module: `line_mode_ctrl`

## Requirements
- R1: Active mode (standby=0, ring=0): hook_n_o is 0 when either qualified detection is present, gkey_n_o is 0 exactly when ground key is qualified, pwr_n_o equals hook_n_o, and inj_en_o is 0.
- R2: Ringing mode (standby=0, ring=1): pwr_n_o is 0, hook_n_o and gkey_n_o follow the same rules as in R1, and inj_en_o is 1 while neither qualified detection is present.
- R3: During ringing, a qualified off-hook drives inj_en_o to 0 in the same cycle that hook_n_o goes to 0.
- R4: During ringing, a qualified ground key alone also drives inj_en_o to 0.
- R5: Once inj_en_o has been cut in ringing mode, it stays 0 after the detections clear, for as long as the synchronized ring request stays 1. Entering ringing again after ring returns to 0 restores inj_en_o to 1.
- R6: Standby with ring=0: hook_n_o=1, gkey_n_o=1, pwr_n_o=1 and inj_en_o=0, whatever the detector inputs are.
- R7: Standby with ring=1: hook_n_o=1, gkey_n_o=1, pwr_n_o=0 and inj_en_o=1, whatever the detector inputs are.
- R8: A detector input held at 1 becomes qualified on the clock edge numbered 2+max(L,1), counted from its first high sample, where L is that detector's limit input. A pulse shorter than L cycles does not become qualified.
- R9: Release is symmetric: after a qualified detector input goes to 0, the detection clears on edge 2+max(L,1).
- R10: The hook limit (hook_lim_i) and the ground-key limit (gkey_lim_i) act independently.
- R11: A change of a mode input appears at the outputs on the second clock edge after it is applied.
- R12: During and right after reset the outputs show the standby-idle pattern (1,1,1,0), and the trip latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Standby request, asynchronous |
| ring_i | input | 1 | Ring request, asynchronous |
| hook_raw_i | input | 1 | Raw loop-current detector, 1 = current present |
| gkey_raw_i | input | 1 | Raw ground-key detector, 1 = ground key present |
| hook_lim_i | input | CNT_W | Hook filter limit in clock ticks |
| gkey_lim_i | input | CNT_W | Ground-key filter limit in clock ticks |
| hook_n_o | output | 1 | Hook status, 0 = off-hook, ground key or ring trip |
| gkey_n_o | output | 1 | Ground-key status, 0 = ground key on |
| pwr_n_o | output | 1 | Codec power-up, 0 = codec enabled |
| inj_en_o | output | 1 | Ringing injector enable, 1 = inject |

## Verification
The bench sweeps every combination of mode and qualified detection against a truth table computed in the bench. A design that decodes one mode wrongly, or lets the detectors leak through in standby, fails there. It measures the filter edges at one cycle before and exactly at the predicted edge for several limits, including zero, and sends pulses one tick too short. An off-by-one counter, a missing synchronizer stage, or a filter that holds state between pulses shows up in those checks. It removes a ring trip while ringing continues, to catch a latch that does not hold. It then withdraws and restores the ring request, to catch a latch that never clears.

// File: rtl/line_mode_ctrl.sv
module line_mode_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_i,
  input  logic             ring_i,
  input  logic             hook_raw_i,
  input  logic             gkey_raw_i,
  input  logic [CNT_W-1:0] hook_lim_i,
  input  logic [CNT_W-1:0] gkey_lim_i,
  output logic             hook_n_o,
  output logic             gkey_n_o,
  output logic             pwr_n_o,
  output logic             inj_en_o
);

  localparam int NDET = 2;

  logic [1:0]      stby_sync, ring_sync;
  logic            stby_q, ring_q;
  logic [NDET-1:0] raw_in, raw_s1, raw_s2, det_q;
  logic [CNT_W-1:0] lim [NDET];
  logic            trip_q;

  assign raw_in = {gkey_raw_i, hook_raw_i};
  assign lim[0] = hook_lim_i;
  assign lim[1] = gkey_lim_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_sync <= 2'b11;
      ring_sync <= 2'b00;
      raw_s1    <= '0;
      raw_s2    <= '0;
    end else begin
      stby_sync <= {stby_sync[0], stby_i};
      ring_sync <= {ring_sync[0], ring_i};
      raw_s1    <= raw_in;
      raw_s2    <= raw_s1;
    end
  end

  assign stby_q = stby_sync[1];
  assign ring_q = ring_sync[1];

  for (genvar i = 0; i < NDET; i++) begin : g_filt
    logic [CNT_W-1:0] cnt, cnt_nx;
    assign cnt_nx = raw_s2[i] ? ((cnt >= lim[i]) ? lim[i] : cnt + 1'b1)
                              : ((cnt == '0) ? '0 : cnt - 1'b1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt      <= '0;
        det_q[i] <= 1'b0;
      end else begin
        cnt <= cnt_nx;
        if (raw_s2[i] && cnt_nx >= lim[i])   det_q[i] <= 1'b1;
        else if (!raw_s2[i] && cnt_nx == '0) det_q[i] <= 1'b0;
      end
    end
  end

  logic hook_q, gkey_q, any_det, ringing;
  assign hook_q  = det_q[0];
  assign gkey_q  = det_q[1];
  assign any_det = hook_q | gkey_q;
  assign ringing = !stby_q && ring_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trip_q <= 1'b0;
    else if (!ring_q) trip_q <= 1'b0;
    else if (ringing && any_det) trip_q <= 1'b1;
  end

  assign hook_n_o = stby_q ? 1'b1 : !any_det;
  assign gkey_n_o = stby_q ? 1'b1 : !gkey_q;
  assign pwr_n_o  = ring_q ? 1'b0 : (stby_q ? 1'b1 : !any_det);
  assign inj_en_o = ring_q && (stby_q || (!trip_q && !any_det));

endmodule

// File: rtl/line_mode_chk.sv
module line_mode_chk (
  input logic clk,
  input logic rst_n,
  input logic stby_q,
  input logic ring_q,
  input logic trip_q,
  input logic hook_n_o,
  input logic gkey_n_o,
  input logic pwr_n_o,
  input logic inj_en_o
);

  AST_ACTIVE_NO_INJ: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_q && !ring_q) |-> (!inj_en_o && pwr_n_o == hook_n_o)); // R1

  AST_GKEY_PULLS_HOOK: assert property (@(posedge clk) disable iff (!rst_n)
    !gkey_n_o |-> !hook_n_o); // R1

  AST_RING_PWR_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_q && ring_q) |-> !pwr_n_o); // R2

  AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_q && ring_q && !hook_n_o) |-> !inj_en_o); // R3

  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_q && ring_q && !inj_en_o) |=> (!(!stby_q && ring_q) || !inj_en_o)); // R5

  AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_q |=> !trip_q); // R5

  AST_STBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_q && !ring_q) |-> (hook_n_o && gkey_n_o && pwr_n_o && !inj_en_o)); // R6

  AST_STBY_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_q && ring_q) |-> (hook_n_o && gkey_n_o && !pwr_n_o && inj_en_o)); // R7

  always @(posedge clk)
    if (!rst_n) AST_RESET_IDLE: assert (hook_n_o && gkey_n_o && pwr_n_o && !inj_en_o); // R12

endmodule

bind line_mode_ctrl line_mode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stby_q(stby_q), .ring_q(ring_q), .trip_q(trip_q),
  .hook_n_o(hook_n_o), .gkey_n_o(gkey_n_o), .pwr_n_o(pwr_n_o), .inj_en_o(inj_en_o)
);

// File: tb/tb_line_mode_ctrl.sv
module tb_line_mode_ctrl;
  localparam int CNT_W = 8;

  logic clk = 0, rst_n = 0;
  logic stby = 1, ring = 0, hraw = 0, graw = 0;
  logic [CNT_W-1:0] hlim = 3, glim = 5;
  logic hook_n, gkey_n, pwr_n, inj;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  line_mode_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .ring_i(ring),
    .hook_raw_i(hraw), .gkey_raw_i(graw), .hook_lim_i(hlim), .gkey_lim_i(glim),
    .hook_n_o(hook_n), .gkey_n_o(gkey_n), .pwr_n_o(pwr_n), .inj_en_o(inj)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {hook_n, gkey_n, pwr_n, inj};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hook_n,gkey_n,pwr_n,inj} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic s, r, h, g);
    logic d;
    d = h | g;
    if (s) return r ? 4'b1101 : 4'b1110;
    if (r) return {~d, ~g, 1'b0, ~d};
    return {~d, ~g, ~d, 1'b0};
  endfunction

  function automatic int dly(input int l);
    return 2 + ((l < 1) ? 1 : l);
  endfunction

  task automatic quiet();
    stby = 0; ring = 0; hraw = 0; graw = 0;
    tick(20);
  endtask

  initial begin
    tick(2);
    chk("R12 reset", 4'b1110);
    rst_n = 1;
    tick(1);
    chk("R12 after reset", 4'b1110);

    // exhaustive mode x detection sweep: R1 R2 R4 R6 R7
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 4; d++) begin
        quiet();
        stby = m[1]; ring = m[0];
        tick(4);
        hraw = d[0]; graw = d[1];
        tick(12);
        case (m)
          0: chk("R1 active", model(0, 0, d[0], d[1]));
          1: chk((d == 2) ? "R4 ring gkey" : "R2 ringing", model(0, 1, d[0], d[1]));
          2: chk("R6 standby idle", model(1, 0, d[0], d[1]));
          default: chk("R7 standby ring", model(1, 1, d[0], d[1]));
        endcase
      end

    // filter edges for several limits: R8 R9 R10
    for (int k = 0; k < 4; k++) begin
      int l;
      l = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 6;
      quiet();
      hlim = CNT_W'(l); glim = 8'd9;
      hraw = 1;
      tick(dly(l) - 1);
      chk("R8 hook before limit", 4'b1110);
      tick(1);
      chk("R8 hook at limit", 4'b0100);
      tick(5);
      hraw = 0;
      tick(dly(l) - 1);
      chk("R9 release before limit", 4'b0100);
      tick(1);
      chk("R9 release at limit", 4'b1110);
      if (l > 1) begin
        tick(10);
        hraw = 1; tick(l - 1); hraw = 0;
        tick(3 * l + 4);
        chk("R8 short pulse ignored", 4'b1110);
      end
    end

    // independent ground-key limit: R10
    quiet();
    hlim = 8'd1; glim = 8'd4;
    graw = 1;
    tick(dly(4) - 1);
    chk("R10 gkey before its limit", 4'b1110);
    tick(1);
    chk("R10 gkey at its limit", 4'b0000);

    // mode sync latency: R11
    quiet();
    hlim = 8'd3; glim = 8'd5;
    ring = 1;
    tick(1);
    chk("R11 one edge", 4'b1110);
    tick(1);
    chk("R11 two edges", 4'b1101);

    // ring trip timing and latch: R3 R5
    hraw = 1;
    tick(dly(3) - 1);
    chk("R3 before trip", 4'b1101);
    tick(1);
    chk("R3 trip cuts", 4'b0100);
    hraw = 0;
    tick(dly(3) + 5);
    chk("R5 latch holds", 4'b1100);
    ring = 0;
    tick(3);
    chk("R5 withdrawn", 4'b1110);
    ring = 1;
    tick(3);
    chk("R5 ringing restored", 4'b1101);

    // gkey trip latch: R4 R5
    graw = 1;
    tick(dly(5) + 1);
    chk("R4 gkey trip", 4'b0000);
    graw = 0;
    tick(dly(5) + 3);
    chk("R5 latch holds after gkey", 4'b1100);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule